// File: doc/BRIEF.md
# Draw Index Generator with Bounds-Checked Fetch

This block turns one draw command into the ordered stream of vertex indices that the rest of a geometry front end consumes. For an indexed draw it reads index elements through a simple request/response memory port, computing each byte address from the buffer base and the element number. For a non-indexed draw it produces a counting sequence and never touches memory. Each complete pass over the draw's elements is tagged with an instance number, and the pass repeats once per instance.

Element reads are bounds-checked against the buffer length given with the command. A read at or past that length, or any read from an empty or null buffer, yields zero without issuing a memory request. These zeros are slotted into the stream in their original order between fetched values, so the consumer sees exactly one index per element. The number of reads in flight is capped, results wait in a small in-order buffer, and the output uses a valid/ready handshake.

Top module: `idx_fetch`

## Requirements
- R1: With `cmd_indexed`=0 the block emits the indices 0, 1, ..., count-1 for every instance and raises no memory request.
- R2: For an indexed draw, element e with e < length and base ≠ 0 is read at byte address base + e·S, where S is 4 when `cmd_wide`=1 and 2 when `cmd_wide`=0; the emitted index is the full 32-bit response when `cmd_wide`=1 and the low 16 bits of the response zero-extended when `cmd_wide`=0.
- R3: An indexed element with e ≥ length is emitted as 0 and issues no memory request.
- R4: When the length is 0 or the base is 0 (null buffer), every element of an indexed draw is emitted as 0 and no memory request is raised.
- R5: A count larger than the length is accepted; elements below the length come from memory and the rest are 0, all in element order.
- R6: The instance field starts at 0 and rises by one after each full pass over the count; a draw emits count × instances outputs in total.
- R7: Memory requests issued minus data consumed never exceeds MAX_OUT.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_index` and `out_instance` hold their values into the next cycle.
- R9: `cmd_ready` is high only when idle; `done` is a one-cycle pulse in the cycle after the last output handshake of the draw, or in the cycle after acceptance when count or instances is 0, in which case nothing is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Draw command offered |
| cmd_ready | output | 1 | Block idle, command accepted on valid |
| cmd_indexed | input | 1 | 1: read indices from memory, 0: counting sequence |
| cmd_wide | input | 1 | 1: 32-bit elements, 0: 16-bit elements |
| cmd_base | input | AW | Byte base address of the index buffer (0 = null) |
| cmd_len | input | CW | Buffer length in elements |
| cmd_count | input | CW | Elements per instance |
| cmd_instances | input | NW | Number of instances |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Byte address of the element |
| mem_resp_valid | input | 1 | Read data returned, in request order |
| mem_resp_data | input | 32 | Read data |
| out_valid | output | 1 | Index available |
| out_ready | input | 1 | Consumer accepts index |
| out_index | output | 32 | Vertex index |
| out_instance | output | NW | Instance number |
| done | output | 1 | Draw finished pulse |

## Verification
The bench sweeps indexed draws over every length from 0 to 4 against every count from 0 to 5 in both element widths, which separates in-range fetches from past-the-end zeros, empty buffers and counts beyond the length, and confirms the 16-bit masking and the address stride. Non-indexed draws over several counts and instance numbers tell the counting path from the fetch path, while a null base with a non-zero length shows the null check is independent of the length check. Runs with a random consumer stall and random memory acceptance and latency expose ordering errors between inserted zeros and late data, hold violations on a stalled output, and a broken cap on reads in flight.

// File: rtl/idxf_pkg.sv
package idxf_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

    localparam int DATA_W = 32;

    // log2 of element size in bytes
    function automatic logic [1:0] elem_shift(input logic wide);
        return wide ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [DATA_W-1:0] narrow(input logic wide, input logic [DATA_W-1:0] w);
        return wide ? w : {16'h0000, w[15:0]};
    endfunction

endpackage

// File: rtl/idxf_fifo.sv
module idxf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt == (PW+1)'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = store[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                store[wp] <= din;
                wp        <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            cnt <= cnt + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/idxf_seq.sv
module idxf_seq
    import idxf_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CW      = 16,
    parameter int NW      = 8,
    parameter int MAX_OUT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_indexed,
    input  logic                cmd_wide,
    input  logic [AW-1:0]       cmd_base,
    input  logic [CW-1:0]       cmd_len,
    input  logic [CW-1:0]       cmd_count,
    input  logic [NW-1:0]       cmd_instances,
    input  logic                slot_free,
    input  logic                slots_empty,
    input  logic                fetched_pop,
    output logic                ent_push,
    output logic                ent_fetched,
    output logic                ent_wide,
    output logic [DATA_W-1:0]   ent_value,
    output logic [NW-1:0]       ent_inst,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [AW-1:0]       mem_req_addr,
    output logic                done
);
    localparam int OW = $clog2(MAX_OUT + 1);

    seq_state_e    state;
    logic          indexed_q, wide_q;
    logic [AW-1:0] base_q;
    logic [CW-1:0] len_q, count_q, elem;
    logic [NW-1:0] ninst_q, inst;
    logic [OW-1:0] inflight;

    logic need_fetch, credit, req_fire;

    assign need_fetch    = indexed_q && (elem < len_q) && (base_q != '0);
    assign credit        = (inflight < OW'(MAX_OUT));
    assign mem_req_valid = (state == SEQ_RUN) && slot_free && need_fetch && credit;
    assign req_fire      = mem_req_valid && mem_req_ready;
    assign ent_push      = (state == SEQ_RUN) && slot_free && (!need_fetch || (credit && mem_req_ready));
    assign mem_req_addr  = base_q + (AW'(elem) << elem_shift(wide_q));

    assign ent_fetched = need_fetch;
    assign ent_wide    = wide_q;
    assign ent_value   = indexed_q ? '0 : DATA_W'(elem);
    assign ent_inst    = inst;

    assign cmd_ready = (state == SEQ_IDLE);
    assign done      = (state == SEQ_DRAIN) && slots_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            inflight <= '0;
            elem     <= '0;
            inst     <= '0;
        end else begin
            inflight <= inflight + (req_fire ? 1'b1 : 1'b0) - (fetched_pop ? 1'b1 : 1'b0);
            unique case (state)
                SEQ_IDLE: if (cmd_valid) begin
                    indexed_q <= cmd_indexed;
                    wide_q    <= cmd_wide;
                    base_q    <= cmd_base;
                    len_q     <= cmd_len;
                    count_q   <= cmd_count;
                    ninst_q   <= cmd_instances;
                    elem      <= '0;
                    inst      <= '0;
                    state     <= (cmd_count == '0 || cmd_instances == '0) ? SEQ_DRAIN : SEQ_RUN;
                end
                SEQ_RUN: if (ent_push) begin
                    if (elem == count_q - 1'b1) begin
                        elem <= '0;
                        if (inst == ninst_q - 1'b1) state <= SEQ_DRAIN;
                        else                        inst  <= inst + 1'b1;
                    end else begin
                        elem <= elem + 1'b1;
                    end
                end
                SEQ_DRAIN: if (slots_empty) state <= SEQ_IDLE;
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assert_inflight_cap_R7: assert property (@(posedge clk) disable iff (rst)
        inflight <= OW'(MAX_OUT));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

// File: rtl/idx_fetch.sv
module idx_fetch
    import idxf_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int NW        = 8,
    parameter int MAX_OUT   = 4,
    parameter int TAG_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_indexed,
    input  logic              cmd_wide,
    input  logic [AW-1:0]     cmd_base,
    input  logic [CW-1:0]     cmd_len,
    input  logic [CW-1:0]     cmd_count,
    input  logic [NW-1:0]     cmd_instances,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [AW-1:0]     mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [31:0]       mem_resp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_index,
    output logic [NW-1:0]     out_instance,
    output logic              done
);
    localparam int TW = 2 + DATA_W + NW;

    logic              ent_push, ent_fetched, ent_wide;
    logic [DATA_W-1:0] ent_value;
    logic [NW-1:0]     ent_inst;
    logic [TW-1:0]     tag_head;
    logic              tag_full, tag_empty, tag_pop;
    logic [DATA_W-1:0] data_head;
    logic              data_full, data_empty, data_pop;

    logic              h_fetched, h_wide;
    logic [DATA_W-1:0] h_value;
    logic [NW-1:0]     h_inst;

    idxf_seq #(.AW(AW), .CW(CW), .NW(NW), .MAX_OUT(MAX_OUT)) seq_i (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_indexed(cmd_indexed), .cmd_wide(cmd_wide),
        .cmd_base(cmd_base), .cmd_len(cmd_len),
        .cmd_count(cmd_count), .cmd_instances(cmd_instances),
        .slot_free(!tag_full), .slots_empty(tag_empty), .fetched_pop(data_pop),
        .ent_push(ent_push), .ent_fetched(ent_fetched), .ent_wide(ent_wide),
        .ent_value(ent_value), .ent_inst(ent_inst),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .done(done)
    );

    // in-order slot per element: fetched flag, width, inserted value, instance
    idxf_fifo #(.W(TW), .DEPTH(TAG_DEPTH)) slot_q (
        .clk(clk), .rst(rst),
        .push(ent_push), .din({ent_fetched, ent_wide, ent_value, ent_inst}),
        .pop(tag_pop), .dout(tag_head), .full(tag_full), .empty(tag_empty)
    );

    // returned read data, sized so that the credit limit can never overrun it
    idxf_fifo #(.W(DATA_W), .DEPTH(MAX_OUT)) data_q (
        .clk(clk), .rst(rst),
        .push(mem_resp_valid), .din(mem_resp_data),
        .pop(data_pop), .dout(data_head), .full(data_full), .empty(data_empty)
    );

    assign {h_fetched, h_wide, h_value, h_inst} = tag_head;

    assign out_valid    = !tag_empty && (!h_fetched || !data_empty);
    assign out_index    = h_fetched ? narrow(h_wide, data_head) : h_value;
    assign out_instance = h_inst;
    assign tag_pop      = out_valid && out_ready;
    assign data_pop     = tag_pop && h_fetched;

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_instance)));
    assert_no_resp_when_full_R7: assert property (@(posedge clk) disable iff (rst)
        mem_resp_valid |-> !data_full);
    assert_no_req_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !mem_req_valid && !out_valid);

endmodule

// File: tb/idx_fetch_tb.sv
`timescale 1ns/1ps
module idx_fetch_tb_top;
    localparam int AW = 32, CW = 16, NW = 8, MAX_OUT = 4;

    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    logic cmd_valid = 0, cmd_ready, cmd_indexed = 0, cmd_wide = 0;
    logic [AW-1:0] cmd_base = '0;
    logic [CW-1:0] cmd_len = '0, cmd_count = '0;
    logic [NW-1:0] cmd_instances = '0;
    logic mem_req_valid, mem_req_ready = 0;
    logic [AW-1:0] mem_req_addr;
    logic mem_resp_valid = 0;
    logic [31:0] mem_resp_data = '0;
    logic out_valid, out_ready = 0;
    logic [31:0] out_index;
    logic [NW-1:0] out_instance;
    logic done;

    idx_fetch #(.AW(AW), .CW(CW), .NW(NW), .MAX_OUT(MAX_OUT)) dut_i (.*);

    int n_checks = 0, n_fail = 0;
    int cycle = 0;
    always @(posedge clk) cycle <= cycle + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycle);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h0001_0DCD) ^ 32'hC3A5_0F00;
    endfunction

    // expected streams
    logic [31:0] exp_idx[$];
    logic [NW-1:0] exp_inst[$];
    logic [31:0] exp_addr[$];
    logic [31:0] resp_q[$];
    int          due_q[$];

    bit   random_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int   in_flight = 0, max_flight = 0;
    int   last_evt = -10;
    bit   done_seen = 0, done_ok = 1, req_ok = 1, ord_ok = 1, hold_ok = 1;
    bit   prev_stall = 0;
    logic [31:0] prev_idx;
    logic [NW-1:0] prev_inst;

    always begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready     = random_mode ? lfsr[0] : 1'b1;
        mem_req_ready = random_mode ? lfsr[3] : 1'b1;
        mem_resp_valid = 0;
        if (resp_q.size() > 0 && due_q[0] <= cycle) begin
            mem_resp_valid = 1;
            mem_resp_data  = resp_q.pop_front();
            void'(due_q.pop_front());
            in_flight--;
        end
        #2;
        if (!rst) begin
            if (prev_stall) begin
                if (!(out_valid && out_index == prev_idx && out_instance == prev_inst)) hold_ok = 0;
                check(out_valid && out_index == prev_idx && out_instance == prev_inst,
                      "R8 hold while stalled", out_index, prev_idx);
            end
            prev_stall = out_valid && !out_ready;
            prev_idx = out_index; prev_inst = out_instance;
            if (mem_req_valid && mem_req_ready) begin
                if (exp_addr.size() == 0) begin
                    req_ok = 0;
                    check(0, "R1/R3/R4 unexpected memory request", mem_req_addr, 0);
                end else begin
                    logic [31:0] ea;
                    ea = exp_addr.pop_front();
                    if (mem_req_addr != ea) begin
                        req_ok = 0;
                        check(0, "R2 request address", mem_req_addr, ea);
                    end
                end
                resp_q.push_back(mem_word(mem_req_addr));
                due_q.push_back(cycle + 2 + (random_mode ? int'(lfsr[7:6]) : 0));
                in_flight++;
                if (in_flight > max_flight) max_flight = in_flight;
            end
            if (out_valid && out_ready) begin
                last_evt = cycle;
                if (exp_idx.size() == 0) begin
                    ord_ok = 0;
                    check(0, "R6 extra output", out_index, 0);
                end else begin
                    logic [31:0] ei; logic [NW-1:0] en;
                    ei = exp_idx.pop_front(); en = exp_inst.pop_front();
                    if (out_index != ei || out_instance != en) begin
                        ord_ok = 0;
                        check(0, "R2/R3/R5 index/instance", {out_instance, out_index}, {en, ei});
                    end
                end
            end
            if (cmd_valid && cmd_ready) last_evt = cycle;
            if (done) begin
                if (done_seen || cycle != last_evt + 1 || exp_idx.size() != 0) done_ok = 0;
                done_seen = 1;
            end
        end
    end

    task automatic run_draw(input bit ix, input bit wide, input logic [31:0] base,
                            input int len, input int cnt, input int ninst, input string tag);
        bit fetch;
        for (int i = 0; i < ninst; i++)
            for (int e = 0; e < cnt; e++) begin
                fetch = ix && (e < len) && (base != 0);
                exp_inst.push_back(NW'(i));
                if (!ix)        exp_idx.push_back(32'(e));
                else if (fetch) begin
                    logic [31:0] a, w;
                    a = base + 32'(e) * (wide ? 4 : 2);
                    w = mem_word(a);
                    exp_addr.push_back(a);
                    exp_idx.push_back(wide ? w : {16'h0, w[15:0]});
                end else exp_idx.push_back(32'h0);
            end
        done_seen = 0; done_ok = 1; req_ok = 1; ord_ok = 1; max_flight = 0;
        @(negedge clk);
        cmd_indexed = ix; cmd_wide = wide; cmd_base = base;
        cmd_len = CW'(len); cmd_count = CW'(cnt); cmd_instances = NW'(ninst);
        cmd_valid = 1;
        do @(posedge clk); while (!cmd_ready);
        @(negedge clk);
        cmd_valid = 0;
        check(!cmd_ready, {"R9 busy after accept ", tag}, cmd_ready, 0);
        for (int t = 0; t < 2000 && !done_seen; t++) @(negedge clk);
        @(negedge clk);
        check(done_seen && done_ok, {"R9 done timing ", tag}, done_ok, 1);
        check(exp_idx.size() == 0 && ord_ok, {"R6 stream complete ", tag}, exp_idx.size(), 0);
        check(exp_addr.size() == 0 && req_ok, {"R2 requests ", tag}, exp_addr.size(), 0);
        check(max_flight <= MAX_OUT, {"R7 reads in flight ", tag}, max_flight, MAX_OUT);
        check(cmd_ready, {"R9 idle after done ", tag}, cmd_ready, 1);
        exp_idx.delete(); exp_inst.delete(); exp_addr.delete();
    endtask

    initial begin : watchdog
        wait (cycle > 150000);
        check(0, "watchdog expired", cycle, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #2;
        check(cmd_ready && !out_valid && !mem_req_valid && !done, "R9 reset state",
              {cmd_ready, out_valid, mem_req_valid, done}, 4'b1000);
        for (int m = 0; m < 2; m++) begin
            random_mode = (m == 1);
            // R1: counting sequence
            for (int c = 1; c <= 6; c++) run_draw(0, 0, 32'h4000, 2, c, 3, "R1 non-indexed");
            // R2 R3 R4 R5: length x count sweep, both widths
            for (int w = 0; w < 2; w++)
                for (int len = 0; len <= 4; len++)
                    for (int c = 0; c <= 5; c++)
                        run_draw(1, w[0], 32'h1000 + 32'(len * 64), len, c, 2, "R5 sweep");
            // R4: null base with non-zero length
            run_draw(1, 1, 32'h0, 5, 4, 2, "R4 null base");
            // R6: many instances
            run_draw(1, 0, 32'h2002, 3, 4, 5, "R6 instances");
            // R9: zero instances
            run_draw(1, 1, 32'h3000, 4, 4, 0, "R9 zero instances");
            // R7: long fetched run under pressure
            run_draw(1, 1, 32'h8000, 40, 40, 1, "R7 long fetch");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule